// File: doc/BRIEF.md
# Chunked Outbound Address Window Decoder

This block sits beside a host-to-PCI bridge and classifies addresses in both directions. For CPU-originated requests it decides whether an address in the top 256 MiB of a 32-bit space goes out to the PCI memory bus. That region is cut into 32 slices of 8 MiB. A slice is forwarded only when three things hold: its bit in a 32-bit slice-enable register is set, a 2-bit mode field holds the enabling code, and the slice is neither the lowest one (boot firmware) nor the highest one (the bridge's own registers). A forwarded request keeps its address unchanged.

For PCI bus-master requests the block steers each address to one of three places. Everything below the end of the first region slice goes to system RAM. The thirty middle slices go back to PCI memory. A small window near the top of the space goes to the CPU side. Anything else matches no target.

Both decoders are combinational and the result is captured in one register stage, so each response appears one clock after its request. Configuration arrives on two plain write ports, and a write affects only the requests that follow it.

Top module: `pci_window_decoder`

## Requirements
- R1: After reset both response valids are 0 and the slice-enable register and mode field are 0, so no outbound request is forwarded until they are written.
- R2: An outbound address whose bits 31:28 are all ones falls in slice addr[27:23]. It is forwarded (ob_rsp_target = 3'b001) when the corresponding slice-enable bit is 1 and the mode is enabling. Otherwise it is local (3'b010).
- R3: Slices 0 and 31 are always local, whatever their enable bits hold.
- R4: The mode field enables forwarding only when it equals 2'b01. The values 2'b00, 2'b10 and 2'b11 make every slice local.
- R5: ob_rsp_addr equals the request address with no translation.
- R6: An outbound address below 0xF0000000 gives target none (3'b100).
- R7: Each response is valid exactly one cycle after its request. When valid, its target is one-hot. When not valid, the target is all zeros.
- R8: A configuration write in the same cycle as a request does not affect that request. It does affect the next request.
- R9: An inbound address below 0xF0800000 gives target RAM (ib_rsp_target = 4'b0001).
- R10: An inbound address from 0xF0800000 to 0xFF7FFFFF gives target PCI (4'b0010).
- R11: An inbound address from 0xFFF00000 to 0xFFFFEFFF gives target CPU (4'b0100).
- R12: Any other inbound address (0xFF800000 to 0xFFEFFFFF, or 0xFFFFF000 and above) gives target none (4'b1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Write strobe for the slice-enable register |
| en_wdata | input | 32 | New slice-enable value, one bit per slice |
| mode_wr | input | 1 | Write strobe for the forwarding mode field |
| mode_wdata | input | 2 | New mode value; 2'b01 enables forwarding |
| ob_req_valid | input | 1 | Outbound request present |
| ob_req_addr | input | 32 | Outbound CPU address |
| ob_rsp_valid | output | 1 | Outbound decision valid |
| ob_rsp_target | output | 3 | One-hot target: bit0 forward, bit1 local, bit2 none |
| ob_rsp_addr | output | 32 | Address presented to PCI |
| ib_req_valid | input | 1 | Inbound bus-master request present |
| ib_req_addr | input | 32 | Inbound PCI address |
| ib_rsp_valid | output | 1 | Inbound decision valid |
| ib_rsp_target | output | 4 | One-hot target: bit0 RAM, bit1 PCI, bit2 CPU, bit3 none |

## Verification
The bench sets enable bits on slices 0 and 31 and confirms they stay local. A decoder that only honours the enable register would forward firmware or bridge-register traffic there. It walks every mode code, which catches a design that tests just one bit of the field. It places a write and a request in the same cycle, which exposes a decoder that reads next-state configuration instead of current state. On the inbound side it probes each range boundary on both sides: the RAM/PCI edge, the PCI/none edge, and both ends of the CPU window. An off-by-one comparison or a wrong slice bound would misroute the edge address.

// File: rtl/pwd_pkg.sv
// Package: shared encodings for the window decoder.
// Assumes one-hot targets; bit order is part of the port contract.
package pwd_pkg;
    typedef enum logic [2:0] {
        OB_NONE_T  = 3'b000,
        OB_FWD     = 3'b001,
        OB_LOCAL   = 3'b010,
        OB_MISS    = 3'b100
    } ob_tgt_e;

    typedef enum logic [3:0] {
        IB_NONE_T  = 4'b0000,
        IB_RAM     = 4'b0001,
        IB_PCI     = 4'b0010,
        IB_CPU     = 4'b0100,
        IB_MISS    = 4'b1000
    } ib_tgt_e;

    localparam logic [1:0] MODE_FWD_ON = 2'b01;
endpackage

// File: rtl/pwd_cfg_regs.sv
// Module: configuration storage for the window decoder.
// Holds the per-slice enable register and the 2-bit mode field and
// derives the global forwarding enable. Assumes plain write strobes.
module pwd_cfg_regs #(
    parameter int NUM_CHUNKS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_wr,
    input  logic [NUM_CHUNKS-1:0] en_wdata,
    input  logic                  mode_wr,
    input  logic [1:0]            mode_wdata,
    output logic [NUM_CHUNKS-1:0] chunk_en,
    output logic                  glob_en
);
    import pwd_pkg::*;

    logic [1:0] mode_q;

    // Per-slice enable flops, one generate branch per slice.
    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_en_bit
        always_ff @(posedge clk) begin
            if (!rst_n)     chunk_en[g] <= 1'b0;
            else if (en_wr) chunk_en[g] <= en_wdata[g];
        end
    end

    // Mode field register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 2'b00;
        else if (mode_wr) mode_q <= mode_wdata;
    end

    // Global enable requires the exact enabling code.
    always_comb glob_en = (mode_q == MODE_FWD_ON);

    // R1: configuration is cleared by reset.
    a_r1_cfg_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (chunk_en == '0 && !glob_en));
endmodule

// File: rtl/pwd_ob_dec.sv
// Module: outbound (CPU to PCI) decoder with one output register.
// The region is the top of the space where the TAG_W high bits are all
// ones. Each slice is 2**CHUNK_LOG2 bytes. The lowest and highest slices
// are never forwarded. Assumes configuration inputs come from flops.
module pwd_ob_dec #(
    parameter int ADDR_W     = 32,
    parameter int TAG_W      = 4,
    parameter int CHUNK_LOG2 = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [(1 << (ADDR_W-TAG_W-CHUNK_LOG2))-1:0] chunk_en,
    input  logic              glob_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [2:0]        rsp_target,
    output logic [ADDR_W-1:0] rsp_addr
);
    import pwd_pkg::*;

    localparam int IDX_W      = ADDR_W - TAG_W - CHUNK_LOG2;
    localparam int NUM_CHUNKS = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHUNKS - 1);

    logic             in_region;
    logic [IDX_W-1:0] idx;
    logic             edge_slice;
    logic             fwd_hit;
    ob_tgt_e          tgt_c;

    // Split the address into region tag and slice index.
    always_comb begin
        in_region  = (req_addr[ADDR_W-1 -: TAG_W] == {TAG_W{1'b1}});
        idx        = req_addr[CHUNK_LOG2 +: IDX_W];
        edge_slice = (idx == '0) || (idx == LAST_IDX);
    end

    // Forward decision: enabled slice, enabling mode, not an edge slice.
    always_comb begin
        fwd_hit = in_region && glob_en && chunk_en[idx] && !edge_slice;
        if (!in_region)   tgt_c = OB_MISS;
        else if (fwd_hit) tgt_c = OB_FWD;
        else              tgt_c = OB_LOCAL;
    end

    // Response register: one cycle of latency, target cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_target <= OB_NONE_T;
            rsp_addr   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_target <= req_valid ? tgt_c : OB_NONE_T;
            if (req_valid) rsp_addr <= req_addr;
        end
    end

    // R7: response follows request by one cycle.
    a_r7_ob_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R7: one-hot target while valid.
    a_r7_ob_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_target) == 1);
    // R7: quiet target while idle.
    a_r7_ob_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_target == 3'b000);
    // R5: address is passed through unchanged.
    a_r5_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_addr == $past(req_addr));
    // R3: edge slices never forward.
    a_r3_edge_local: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_target[0] |-> (rsp_addr[CHUNK_LOG2 +: IDX_W] != '0 &&
                           rsp_addr[CHUNK_LOG2 +: IDX_W] != LAST_IDX));
    // R4: forwarding requires the enable seen when the request arrived.
    a_r4_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_target[0] |-> $past(glob_en));
    // R6: addresses below the region never match.
    a_r6_below_region: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_addr[ADDR_W-1 -: TAG_W] != {TAG_W{1'b1}})
        |-> rsp_target == 3'b100);
endmodule

// File: rtl/pwd_ib_dec.sv
// Module: inbound (bus-master) decoder with one output register.
// Below the end of region slice 0 maps to RAM. The middle slices map to
// PCI. A fixed window in the last slice maps to the CPU side. Assumes the
// CPU window lies within the last slice.
module pwd_ib_dec #(
    parameter int          ADDR_W     = 32,
    parameter int          TAG_W      = 4,
    parameter int          CHUNK_LOG2 = 23,
    parameter logic [31:0] CPU_LO     = 32'hFFF0_0000,
    parameter logic [31:0] CPU_HI     = 32'hFFFF_EFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [3:0]        rsp_target
);
    import pwd_pkg::*;

    localparam int IDX_W      = ADDR_W - TAG_W - CHUNK_LOG2;
    localparam int NUM_CHUNKS = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHUNKS - 1);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(CPU_LO);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(CPU_HI);

    logic             in_region;
    logic [IDX_W-1:0] idx;
    ib_tgt_e          tgt_c;
    logic [ADDR_W-1:0] q_addr;

    // Region tag and slice index of the inbound address.
    always_comb begin
        in_region = (req_addr[ADDR_W-1 -: TAG_W] == {TAG_W{1'b1}});
        idx       = req_addr[CHUNK_LOG2 +: IDX_W];
    end

    // Steering: RAM, then middle slices to PCI, then CPU window, else miss.
    always_comb begin
        if (!in_region || idx == '0)              tgt_c = IB_RAM;
        else if (idx != LAST_IDX)                 tgt_c = IB_PCI;
        else if (req_addr >= WIN_LO && req_addr <= WIN_HI) tgt_c = IB_CPU;
        else                                      tgt_c = IB_MISS;
    end

    // Response register; the address copy serves the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_target <= IB_NONE_T;
            q_addr     <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_target <= req_valid ? tgt_c : IB_NONE_T;
            if (req_valid) q_addr <= req_addr;
        end
    end

    // R7: response follows request by one cycle.
    a_r7_ib_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R7: one-hot while valid, zero while idle.
    a_r7_ib_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_target) == 1);
    a_r7_ib_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_target == 4'b0000);
    // R11: CPU target only inside the CPU window.
    a_r11_cpu_window: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_target[2] |-> (q_addr >= WIN_LO && q_addr <= WIN_HI));
    // R9: RAM target only at or below the end of slice 0.
    a_r9_ram_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_target[0] |-> (q_addr[ADDR_W-1 -: TAG_W] != {TAG_W{1'b1}} ||
                           q_addr[CHUNK_LOG2 +: IDX_W] == '0));
endmodule

// File: rtl/pci_window_decoder.sv
// Module: top of the chunked address window decoder.
// Couples the configuration registers to the outbound and inbound
// decoders. Assumes config writes and requests are synchronous to clk.
module pci_window_decoder #(
    parameter int          ADDR_W     = 32,
    parameter int          TAG_W      = 4,
    parameter int          CHUNK_LOG2 = 23,
    parameter logic [31:0] CPU_LO     = 32'hFFF0_0000,
    parameter logic [31:0] CPU_HI     = 32'hFFFF_EFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_wr,
    input  logic [31:0] en_wdata,
    input  logic        mode_wr,
    input  logic [1:0]  mode_wdata,
    input  logic        ob_req_valid,
    input  logic [31:0] ob_req_addr,
    output logic        ob_rsp_valid,
    output logic [2:0]  ob_rsp_target,
    output logic [31:0] ob_rsp_addr,
    input  logic        ib_req_valid,
    input  logic [31:0] ib_req_addr,
    output logic        ib_rsp_valid,
    output logic [3:0]  ib_rsp_target
);
    localparam int NUM_CHUNKS = 1 << (ADDR_W - TAG_W - CHUNK_LOG2);

    logic [NUM_CHUNKS-1:0] chunk_en;
    logic                  glob_en;

    pwd_cfg_regs #(.NUM_CHUNKS(NUM_CHUNKS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata[NUM_CHUNKS-1:0]),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .chunk_en   (chunk_en),
        .glob_en    (glob_en)
    );

    pwd_ob_dec #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CHUNK_LOG2(CHUNK_LOG2)) u_ob (
        .clk        (clk),
        .rst_n      (rst_n),
        .chunk_en   (chunk_en),
        .glob_en    (glob_en),
        .req_valid  (ob_req_valid),
        .req_addr   (ob_req_addr),
        .rsp_valid  (ob_rsp_valid),
        .rsp_target (ob_rsp_target),
        .rsp_addr   (ob_rsp_addr)
    );

    pwd_ib_dec #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CHUNK_LOG2(CHUNK_LOG2),
                 .CPU_LO(CPU_LO), .CPU_HI(CPU_HI)) u_ib (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (ib_req_valid),
        .req_addr   (ib_req_addr),
        .rsp_valid  (ib_rsp_valid),
        .rsp_target (ib_rsp_target)
    );

    // R8: a same-cycle write cannot affect the request's forwarding.
    a_r8_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_req_valid && mode_wr && mode_wdata == 2'b01 && !glob_en)
        |=> !ob_rsp_target[0]);
endmodule

// File: tb/pci_window_decoder_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module pci_window_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0;
    logic [31:0] en_wdata = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic        ob_req_valid = 1'b0;
    logic [31:0] ob_req_addr = '0;
    logic        ob_rsp_valid;
    logic [2:0]  ob_rsp_target;
    logic [31:0] ob_rsp_addr;
    logic        ib_req_valid = 1'b0;
    logic [31:0] ib_req_addr = '0;
    logic        ib_rsp_valid;
    logic [3:0]  ib_rsp_target;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [2:0] FWD = 3'b001, LOC = 3'b010, MISS = 3'b100;
    localparam logic [3:0] RAM = 4'b0001, PCI = 4'b0010, CPU = 4'b0100, NONE = 4'b1000;

    always #10 clk = ~clk; // 50 MHz

    pci_window_decoder u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slice_addr(input int i, input logic [22:0] off);
        return 32'hF000_0000 + (i << 23) + {9'd0, off};
    endfunction

    task automatic wr_en(input logic [31:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic [1:0] v);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic ob_probe(input string req, input logic [31:0] a, input logic [2:0] exp);
        @(negedge clk); ob_req_valid = 1'b1; ob_req_addr = a;
        @(negedge clk); ob_req_valid = 1'b0;
        chk(req, {31'd0, ob_rsp_valid}, 32'd1);
        chk(req, {29'd0, ob_rsp_target}, {29'd0, exp});
    endtask

    task automatic ib_probe(input string req, input logic [31:0] a, input logic [3:0] exp);
        @(negedge clk); ib_req_valid = 1'b1; ib_req_addr = a;
        @(negedge clk); ib_req_valid = 1'b0;
        chk(req, {31'd0, ib_rsp_valid}, 32'd1);
        chk(req, {28'd0, ib_rsp_target}, {28'd0, exp});
    endtask

    task automatic t_reset();
        chk("R1 ob valid", {31'd0, ob_rsp_valid}, 32'd0);
        chk("R1 ib valid", {31'd0, ib_rsp_valid}, 32'd0);
        ob_probe("R1 unconfigured slice", slice_addr(5, 23'h10), LOC);
    endtask

    task automatic t_forward();
        wr_en(32'hFFFF_FFFF);
        wr_mode(2'b01);
        ob_probe("R2 slice 5 forward", slice_addr(5, 23'h1234), FWD);
        chk("R5 addr passthrough", ob_rsp_addr, slice_addr(5, 23'h1234));
        ob_probe("R2 slice 30 forward", slice_addr(30, 23'h7F_FFFF), FWD);
        chk("R5 addr passthrough 30", ob_rsp_addr, slice_addr(30, 23'h7F_FFFF));
        ob_probe("R3 slice 0 local", slice_addr(0, 23'h40), LOC);
        ob_probe("R3 slice 31 local", slice_addr(31, 23'h40), LOC);
        ob_probe("R6 below region", 32'h1234_5678, MISS);
        ob_probe("R6 just below region", 32'hEFFF_FFFF, MISS);
        wr_en(32'hFFFF_FFDF);
        ob_probe("R2 disabled slice 5", slice_addr(5, 23'h0), LOC);
        ob_probe("R2 slice 6 still on", slice_addr(6, 23'h0), FWD);
    endtask

    task automatic t_modes();
        wr_mode(2'b00); ob_probe("R4 mode 00", slice_addr(1, 23'h0), LOC);
        wr_mode(2'b10); ob_probe("R4 mode 10", slice_addr(1, 23'h0), LOC);
        wr_mode(2'b11); ob_probe("R4 mode 11", slice_addr(1, 23'h0), LOC);
        wr_mode(2'b01); ob_probe("R4 mode 01", slice_addr(1, 23'h0), FWD);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R7 idle valid", {31'd0, ob_rsp_valid}, 32'd0);
        chk("R7 idle target", {29'd0, ob_rsp_target}, 32'd0);
        chk("R7 ib idle target", {28'd0, ib_rsp_target}, 32'd0);
    endtask

    task automatic t_order();
        // Request and a disabling write in the same cycle.
        @(negedge clk);
        ob_req_valid = 1'b1; ob_req_addr = slice_addr(9, 23'h0);
        mode_wr = 1'b1; mode_wdata = 2'b00;
        @(negedge clk);
        ob_req_valid = 1'b1; ob_req_addr = slice_addr(9, 23'h0);
        mode_wr = 1'b0;
        chk("R8 same-cycle uses old mode", {29'd0, ob_rsp_target}, {29'd0, FWD});
        @(negedge clk);
        ob_req_valid = 1'b0;
        chk("R8 next request sees new mode", {29'd0, ob_rsp_target}, {29'd0, LOC});
    endtask

    task automatic t_inbound();
        ib_probe("R9 zero", 32'h0000_0000, RAM);
        ib_probe("R9 top of ram", 32'hF07F_FFFF, RAM);
        ib_probe("R10 first pci", 32'hF080_0000, PCI);
        ib_probe("R10 last pci", 32'hFF7F_FFFF, PCI);
        ib_probe("R12 after pci", 32'hFF80_0000, NONE);
        ib_probe("R12 below cpu", 32'hFFEF_FFFF, NONE);
        ib_probe("R11 cpu low", 32'hFFF0_0000, CPU);
        ib_probe("R11 cpu high", 32'hFFFF_EFFF, CPU);
        ib_probe("R12 above cpu", 32'hFFFF_F000, NONE);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_modes();
        t_idle();
        t_order();
        t_inbound();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule